// File: doc/BRIEF.md
# Token-Ring Cascadable FIFO

A first-in first-out buffer of 9-bit words. It stores words in a dual-port memory that has a separate write pointer and read pointer, so a write and a read can both happen in the same clock. The depth is a parameter and must be 256, 512, 1024, 2048 or 4096 words. The whole block runs on one clock. Both the write side and the read side are valid/ready streams. The status flags are active low: not empty, not more than half full, and not full.

Instances can be chained to make a deeper FIFO. Every device in the chain shares the same write bus and read bus. Only the device that holds the write token accepts words. Only the device that holds the read token presents words. When a device writes its last physical location, it gives the write token to the next device with a one-cycle low pulse on its write expansion output. The read token passes in the same way when a device reads its last physical location. The expansion output of the last device loops back to the first device, so the chain is a closed ring. The first-load input marks the device that holds both tokens after master reset.

Back-pressure rules. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while the device lacks the write token, is full, or is in reset. A word is removed on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value.

Top module: `tokring_fifo`

## Requirements
- R1: Words come out in the order they were written, and all 9 bits are kept. DEPTH must be one of 256, 512, 1024, 2048 or 4096.
- R2: In the cycle after master reset is released (`mr_n` high), the flags read `empty_n`=0, `half_n`=1 and `full_n`=1, and `out_valid`=0.
- R3: While `mr_n` is low, `in_ready` and `out_valid` are 0, and any `in_valid` or `out_ready` activity is ignored. The FIFO is still empty after reset is released.
- R4: If the FIFO is empty, for example right after reset, `out_valid` stays 0 and `out_ready` has no effect. The first word written afterwards is the first word read.
- R5: `full_n` is 0 exactly when DEPTH words are stored. `in_ready` is then 0, and words offered while full are never stored.
- R6: `half_n` is 0 exactly when more than DEPTH/2 words are stored. With DEPTH/2 words it is still 1.
- R7: A write to the last physical location drives `wr_xo_n` to 0 for exactly the one cycle after the write edge. From that edge on, the device's `in_ready` stays 0 until it takes the write token back.
- R8: A read from the last physical location drives `rd_xo_n` to 0 for exactly the one cycle after the read edge. From that edge on, the device's `out_valid` stays 0 until it takes the read token back.
- R9: A device gets the write token (or the read token) on the edge where it samples `wr_xi_n` (or `rd_xi_n`) low. It also gets both tokens at reset when `first_load` is 1. A device with `first_load`=0 shows `in_ready`=0 and `out_valid`=0 after reset. Its pointers move only on accepted transfers, and a transfer is accepted only while the device holds the matching token.
- R10: Two devices joined in a ring hold 2*DEPTH words. Word order is kept across the device boundary in both directions. After the ring wraps, the tokens are back at the first device.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays the same on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mr_n | input | 1 | Master reset, active low, synchronous |
| first_load | input | 1 | Device holds both tokens after reset |
| in_valid | input | 1 | Write request |
| in_ready | output | 1 | Word accepted on this edge if valid |
| in_data | input | 9 | Write word |
| out_valid | output | 1 | Read word available from this device |
| out_ready | input | 1 | Read request |
| out_data | output | 9 | Read word |
| empty_n | output | 1 | Low when nothing is stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| wr_xi_n | input | 1 | Write-token pulse from previous device |
| wr_xo_n | output | 1 | Write-token pulse to next device |
| rd_xi_n | input | 1 | Read-token pulse from previous device |
| rd_xo_n | output | 1 | Read-token pulse to next device |

## Verification
The hardest state to reach is the device boundary. One device has filled its last location and passed the write token on, while its read token is still at home. Later the read token has to cross the same boundary and the ring has to wrap back to the first device. The bench builds a two-device ring with the default depth. It writes all 2*DEPTH words while checking the flags after every write and the token pulses at each boundary. It then offers words against the full ring, drains the ring, and finally runs a long mixed stream with irregular valid and ready patterns that laps the ring more than once.

// File: rtl/tokring_pkg.sv
package tokring_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/tokring_mem.sv
module tokring_mem #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  tokring_pkg::word_t    wdata,
  input  logic [AW-1:0]         raddr,
  output tokring_pkg::word_t    rdata
);
  tokring_pkg::word_t store [DEPTH];

  // write port: one word per accepted edge
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // read port: independent address, combinational look-up
  assign rdata = store[raddr];
endmodule

// File: rtl/tokring_token.sv
module tokring_token #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          mr_n,
  input  logic          first_load,
  input  logic          tok_in_n,
  input  logic          fire,
  output logic          has_tok,
  output logic [AW-1:0] ptr,
  output logic          tok_out_n
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic at_last;
  assign at_last = (ptr == LAST);

  always_ff @(posedge clk) begin
    if (!mr_n) begin
      has_tok   <= first_load;
      ptr       <= '0;
      tok_out_n <= 1'b1;
    end else begin
      tok_out_n <= 1'b1;
      if (fire) begin
        ptr <= at_last ? '0 : ptr + 1'b1;
        if (at_last) begin
          has_tok   <= 1'b0;
          tok_out_n <= 1'b0;
        end
      end
      if (!tok_in_n) has_tok <= 1'b1;
    end
  end

  AST_FIRE_HOLDS_TOKEN: assert property (@(posedge clk) disable iff (!mr_n)
    fire |-> has_tok); // R9
  AST_HANDOFF_LAST: assert property (@(posedge clk) disable iff (!mr_n)
    (fire && at_last && tok_in_n) |=> (!has_tok && !tok_out_n)); // R7
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!mr_n)
    !tok_out_n |=> tok_out_n); // R8
  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!mr_n)
    !fire |=> $stable(ptr)); // R9
endmodule

// File: rtl/tokring_level.sv
module tokring_level #(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic mr_n,
  input  logic wr_fire,
  input  logic rd_fire,
  output logic empty_n,
  output logic half_n,
  output logic full_n
);
  localparam logic [CW-1:0] TOP  = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (!mr_n) begin
      count <= '0;
    end else begin
      unique case ({wr_fire, rd_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign empty_n = (count != '0);
  assign half_n  = !(count > HALF);
  assign full_n  = (count != TOP);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!mr_n)
    (count == TOP) |-> !wr_fire); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!mr_n)
    (count == '0) |-> !rd_fire); // R4
  AST_HALF_CROSS: assert property (@(posedge clk) disable iff (!mr_n)
    (wr_fire && !rd_fire && count == HALF) |=> !half_n); // R6
endmodule

// File: rtl/tokring_fifo.sv
module tokring_fifo #(
  parameter int DEPTH = 256
) (
  input  logic               clk,
  input  logic               mr_n,
  input  logic               first_load,
  input  logic               in_valid,
  output logic               in_ready,
  input  tokring_pkg::word_t in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output tokring_pkg::word_t out_data,
  output logic               empty_n,
  output logic               half_n,
  output logic               full_n,
  input  logic               wr_xi_n,
  output logic               wr_xo_n,
  input  logic               rd_xi_n,
  output logic               rd_xo_n
);
  localparam int AW = $clog2(DEPTH);

  generate
    if (DEPTH != 256 && DEPTH != 512 && DEPTH != 1024 &&
        DEPTH != 2048 && DEPTH != 4096) begin : g_bad_depth
      $error("tokring_fifo: DEPTH must be 256, 512, 1024, 2048 or 4096"); // R1
    end
  endgenerate

  logic          wr_tok, rd_tok;
  logic [AW-1:0] wptr, rptr;
  logic          wr_fire, rd_fire;

  assign in_ready  = mr_n && wr_tok && full_n;
  assign out_valid = mr_n && rd_tok && empty_n;
  assign wr_fire   = in_valid && in_ready;
  assign rd_fire   = out_valid && out_ready;

  tokring_token #(.DEPTH(DEPTH), .AW(AW)) u_wtok (
    .clk(clk), .mr_n(mr_n), .first_load(first_load), .tok_in_n(wr_xi_n),
    .fire(wr_fire), .has_tok(wr_tok), .ptr(wptr), .tok_out_n(wr_xo_n)
  );

  tokring_token #(.DEPTH(DEPTH), .AW(AW)) u_rtok (
    .clk(clk), .mr_n(mr_n), .first_load(first_load), .tok_in_n(rd_xi_n),
    .fire(rd_fire), .has_tok(rd_tok), .ptr(rptr), .tok_out_n(rd_xo_n)
  );

  tokring_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .mr_n(mr_n), .wr_fire(wr_fire), .rd_fire(rd_fire),
    .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
  );

  tokring_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(wr_fire), .waddr(wptr), .wdata(in_data),
    .raddr(rptr), .rdata(out_data)
  );

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!mr_n)
    $rose(mr_n) |-> (!empty_n && half_n && full_n && !out_valid)); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!mr_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R11
  AST_WR_LOSES_TOKEN: assert property (@(posedge clk) disable iff (!mr_n)
    !wr_xo_n |-> !in_ready); // R7
  AST_RD_LOSES_TOKEN: assert property (@(posedge clk) disable iff (!mr_n)
    !rd_xo_n |-> !out_valid); // R8
endmodule

// File: tb/tokring_fifo_bench.sv
`timescale 1ns/1ps
module tokring_fifo_bench;
  localparam int DEPTH = 256;
  localparam int RING  = 2 * DEPTH;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic mr_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [8:0] in_data = '0;

  logic a_ir, b_ir, a_ov, b_ov;
  logic [8:0] a_od, b_od;
  logic a_en, a_hn, a_fn, b_en, b_hn, b_fn;
  logic a_wxo, b_wxo, a_rxo, b_rxo;

  tokring_fifo #(.DEPTH(DEPTH)) u_tokring_fifo (
    .clk(clk), .mr_n(mr_n), .first_load(1'b1),
    .in_valid(in_valid), .in_ready(a_ir), .in_data(in_data),
    .out_valid(a_ov), .out_ready(out_ready), .out_data(a_od),
    .empty_n(a_en), .half_n(a_hn), .full_n(a_fn),
    .wr_xi_n(b_wxo), .wr_xo_n(a_wxo), .rd_xi_n(b_rxo), .rd_xo_n(a_rxo)
  );

  tokring_fifo #(.DEPTH(DEPTH)) u_tokring_fifo_b (
    .clk(clk), .mr_n(mr_n), .first_load(1'b0),
    .in_valid(in_valid), .in_ready(b_ir), .in_data(in_data),
    .out_valid(b_ov), .out_ready(out_ready), .out_data(b_od),
    .empty_n(b_en), .half_n(b_hn), .full_n(b_fn),
    .wr_xi_n(a_wxo), .wr_xo_n(b_wxo), .rd_xi_n(a_rxo), .rd_xo_n(b_rxo)
  );

  logic rdy_c, ov_c;
  logic [8:0] od_c;
  assign rdy_c = a_ir | b_ir;
  assign ov_c  = a_ov | b_ov;
  assign od_c  = a_ov ? a_od : b_od;

  int n_chk = 0;
  int n_bad = 0;
  int wr_n = 0;
  int rd_n = 0;

  function automatic logic [8:0] word_of(input int i);
    return 9'((i * 37 + 11) % 512);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // offer one word, return at the negedge after it is taken
  task automatic push();
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = word_of(wr_n);
    while (!rdy_c) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wr_n++;
  endtask

  // take one word, check its value against the arithmetic order
  task automatic pop();
    @(negedge clk);
    while (!ov_c) @(negedge clk);
    chk(od_c == word_of(rd_n), "R1 R10 order", od_c, word_of(rd_n));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    rd_n++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    // R3: strobes held active during reset
    in_valid = 1'b1; out_ready = 1'b1; in_data = 9'h155;
    repeat (5) @(negedge clk);
    chk(!a_ir && !b_ir, "R3 in_ready in reset", a_ir, 0);
    chk(!ov_c, "R3 out_valid in reset", ov_c, 0);
    in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk); mr_n = 1'b1;
    @(negedge clk);
    // R2
    chk({a_en, a_hn, a_fn} == 3'b011, "R2 flags after reset", {a_en, a_hn, a_fn}, 3);
    chk(!a_ov, "R2 out_valid after reset", a_ov, 0);
    // R9: first_load selects the holder
    chk(a_ir && !b_ir, "R9 token at first_load device", {a_ir, b_ir}, 2);
    chk(!b_ov, "R9 other device no read token", b_ov, 0);

    // R4: read attempts on empty
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(!ov_c, "R4 empty read gives nothing", ov_c, 0);
    out_ready = 1'b0;
    chk(!a_en, "R4 still empty", a_en, 0);

    // fill device A, flag sweep after each write (R5 R6)
    for (int i = 1; i <= DEPTH; i++) begin
      push();
      chk(a_en == 1'b1, "R2 empty_n while filling", a_en, 1);
      chk(a_hn == !(i > DEPTH / 2), "R6 half_n sweep", a_hn, !(i > DEPTH / 2));
      chk(a_fn == (i != DEPTH), "R5 full_n sweep", a_fn, i != DEPTH);
    end
    // R7: handoff pulse and token drop
    chk(!a_wxo, "R7 wr_xo_n low after last write", a_wxo, 0);
    chk(!a_ir, "R7 in_ready dropped", a_ir, 0);
    @(negedge clk);
    chk(a_wxo, "R7 wr_xo_n one cycle", a_wxo, 1);
    chk(b_ir, "R9 next device took write token", b_ir, 1);

    // fill device B
    for (int i = 1; i <= DEPTH; i++) push();
    chk(!b_wxo, "R7 B pulse on last write", b_wxo, 0);
    @(negedge clk);
    chk(!rdy_c, "R5 ring full no ready", rdy_c, 0);
    chk(!a_fn && !b_fn, "R5 both full", {a_fn, b_fn}, 0);
    // offer words against the full ring
    in_valid = 1'b1; in_data = 9'h1AA;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;

    // R11: hold while not ready
    @(negedge clk);
    chk(ov_c && od_c == word_of(0), "R11 head presented", od_c, word_of(0));
    @(negedge clk);
    chk(ov_c && od_c == word_of(0), "R11 head held", od_c, word_of(0));

    // drain A
    for (int i = 1; i <= DEPTH; i++) pop();
    chk(!a_rxo, "R8 rd_xo_n low after last read", a_rxo, 0);
    chk(!a_ov, "R8 out_valid dropped", a_ov, 0);
    @(negedge clk);
    chk(a_rxo, "R8 rd_xo_n one cycle", a_rxo, 1);
    chk(b_ov, "R9 next device took read token", b_ov, 1);
    chk(a_fn && !a_en, "R5 A empty after drain", {a_fn, a_en}, 2);

    // drain B (words offered while full must not show up: R5)
    for (int i = 1; i <= DEPTH; i++) pop();
    repeat (2) @(negedge clk);
    chk(!ov_c, "R5 R10 nothing extra after drain", ov_c, 0);
    chk(a_ir && !b_ir, "R10 write token back home", {a_ir, b_ir}, 2);

    // mixed stream laps the ring (R1 R10 R11)
    fork
      begin
        for (int i = 0; i < 700; i++) begin
          if (i % 3 == 1) @(negedge clk);
          push();
        end
      end
      begin
        for (int i = 0; i < 700; i++) begin
          if (i % 5 == 2) repeat (2) @(negedge clk);
          pop();
        end
      end
    join
    repeat (2) @(negedge clk);
    chk(!ov_c && !a_en && !b_en, "R10 ring empty at end", ov_c, 0);
    chk(rd_n == wr_n, "R1 counts match", rd_n, wr_n);

    summary();
    $finish;
  end
endmodule